// File: doc/BRIEF.md
# Duplicated Stuff-Acknowledge Selector with Twin Comparison

The block picks one channel's positive-stuff request and one channel's negative-stuff request out of a bank of channels, once per minor frame, using a channel address. Each of the two selection paths is built twice: a functional copy, whose result goes back to the overhead logic as the positive and negative stuff acknowledge, and a diagnostic copy driven from its own copy of the channel address. On every frame strobe the two copies are compared, and any disagreement raises a one-cycle stuff error toward the composite error collector.

Channels that are switched out of service have their positive input replaced by the self-test level before either positive path sees it, so during self-test those channels read a known value in both copies and cannot cause a false mismatch. When the frame strobe falls on word 24, the functional positive acknowledge is also captured as a diagnostic sample.

All interfaces are plain control pins. The word-24 sample is a single-cycle valid strobe with no ready: the receiver must take it in the cycle it appears, and there is no back-pressure.

Top module: `stuff_twin_checker`

## Requirements
- R1: While `rst_n` is low and in the first cycle after, `pos_ack`, `neg_ack`, `pos_err`, `neg_err`, `stuff_err`, `w24_valid` and `w24_data` are all 0.
- R2: One cycle after a clock edge with `frame_tick` high, `pos_ack` equals the conditioned positive input of channel `chan_sel` and `neg_ack` equals `neg_req[chan_sel]` (bit i of each request bus belongs to channel i).
- R3: `pos_ack` and `neg_ack` keep their value in every cycle that does not follow a `frame_tick`.
- R4: One cycle after a `frame_tick`, `pos_err` is 1 exactly when the conditioned positive inputs of channels `chan_sel` and `diag_sel` differ; it is 0 in all other cycles.
- R5: One cycle after a `frame_tick`, `neg_err` is 1 exactly when `neg_req[chan_sel]` and `neg_req[diag_sel]` differ; it is 0 in all other cycles.
- R6: `stuff_err` is 1 in exactly the cycles where `pos_err` or `neg_err` is 1.
- R7: The conditioned positive input of channel i is `pos_req[i]` when `chan_on[i]` is 1 and the `self_test` level when `chan_on[i]` is 0; negative inputs are never conditioned.
- R8: With `self_test` high, selecting an out-of-service channel yields `pos_ack` 1 and no positive mismatch against another out-of-service channel, whatever `pos_req` holds.
- R9: One cycle after a `frame_tick` with `word24` high, `w24_valid` is 1 and `w24_data` equals the new `pos_ack`; otherwise `w24_valid` is 0 and `w24_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle minor-frame interrogation strobe |
| word24 | input | 1 | High when the current frame strobe falls on word 24 |
| chan_sel | input | 4 | Channel address for the functional pair |
| diag_sel | input | 4 | Duplicated channel address for the diagnostic pair |
| pos_req | input | 16 | Positive-stuff request per channel |
| neg_req | input | 16 | Negative-stuff request per channel |
| chan_on | input | 16 | Per-channel in-service flag |
| self_test | input | 1 | Self-test level applied to out-of-service positive inputs |
| pos_ack | output | 1 | Functional positive stuff acknowledge |
| neg_ack | output | 1 | Functional negative stuff acknowledge |
| pos_err | output | 1 | Positive twin mismatch pulse |
| neg_err | output | 1 | Negative twin mismatch pulse |
| stuff_err | output | 1 | Combined stuff error to the composite collector |
| w24_valid | output | 1 | Word-24 sample strobe |
| w24_data | output | 1 | Sampled positive acknowledge |

## Verification
Every channel address is swept against several request patterns: a single set bit on the chosen channel, a single clear bit, alternating bits and an arithmetic scramble, which tell a correct index from a neighbouring or inverted one. Each frame is run with the diagnostic address equal to the functional one, which must give no error, and with it offset, where the expected error follows from whether the two picked bits differ, separating the positive and negative paths. Sweeps repeat with a partial in-service mask and self-test both low and high, showing that only out-of-service positive inputs are replaced, and word 24 is toggled to show the sample is taken only on that word.

// File: rtl/stuff_chk_pkg.sv
package stuff_chk_pkg;
  localparam int N_POL = 2;
  typedef enum int {POL_POS = 0, POL_NEG = 1} pol_e;
endpackage

// File: rtl/chan_pick.sv
module chan_pick #(
  parameter int N_CH  = 16,
  parameter int SEL_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0]  din,
  input  logic [SEL_W-1:0] sel,
  output logic             bit_o
);
  always_comb begin
    bit_o = 1'b0;
    for (int i = 0; i < N_CH; i++) begin
      if (sel == SEL_W'(i)) bit_o = din[i];
    end
  end
endmodule

// File: rtl/test_level_cond.sv
module test_level_cond #(
  parameter int N_CH = 16
) (
  input  logic [N_CH-1:0] raw,
  input  logic [N_CH-1:0] in_service,
  input  logic            level,
  output logic [N_CH-1:0] cond
);
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign cond[g] = in_service[g] ? raw[g] : level;
  end
endmodule

// File: rtl/twin_compare.sv
module twin_compare (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic func_bit,
  input  logic diag_bit,
  output logic ack,
  output logic err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack <= 1'b0;
      err <= 1'b0;
    end else begin
      err <= tick & (func_bit ^ diag_bit);
      if (tick) ack <= func_bit;
    end
  end
endmodule

// File: rtl/stuff_twin_checker.sv
module stuff_twin_checker #(
  parameter int N_CH  = 16,
  parameter int SEL_W = $clog2(N_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic             word24,
  input  logic [SEL_W-1:0] chan_sel,
  input  logic [SEL_W-1:0] diag_sel,
  input  logic [N_CH-1:0]  pos_req,
  input  logic [N_CH-1:0]  neg_req,
  input  logic [N_CH-1:0]  chan_on,
  input  logic             self_test,
  output logic             pos_ack,
  output logic             neg_ack,
  output logic             pos_err,
  output logic             neg_err,
  output logic             stuff_err,
  output logic             w24_valid,
  output logic             w24_data
);
  import stuff_chk_pkg::*;

  logic [N_CH-1:0]  pos_cond;
  logic [N_CH-1:0]  bus   [N_POL];
  logic [N_POL-1:0] f_bit;
  logic [N_POL-1:0] d_bit;
  logic [N_POL-1:0] ack_v;
  logic [N_POL-1:0] err_v;

  test_level_cond #(.N_CH(N_CH)) u_cond (
    .raw(pos_req), .in_service(chan_on), .level(self_test), .cond(pos_cond)
  );

  assign bus[POL_POS] = pos_cond;
  assign bus[POL_NEG] = neg_req;

  for (genvar p = 0; p < N_POL; p++) begin : g_pol
    chan_pick #(.N_CH(N_CH), .SEL_W(SEL_W)) u_func (
      .din(bus[p]), .sel(chan_sel), .bit_o(f_bit[p])
    );
    chan_pick #(.N_CH(N_CH), .SEL_W(SEL_W)) u_diag (
      .din(bus[p]), .sel(diag_sel), .bit_o(d_bit[p])
    );
    twin_compare u_cmp (
      .clk(clk), .rst_n(rst_n), .tick(frame_tick),
      .func_bit(f_bit[p]), .diag_bit(d_bit[p]),
      .ack(ack_v[p]), .err(err_v[p])
    );
  end

  assign pos_ack   = ack_v[POL_POS];
  assign neg_ack   = ack_v[POL_NEG];
  assign pos_err   = err_v[POL_POS];
  assign neg_err   = err_v[POL_NEG];
  assign stuff_err = |err_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w24_valid <= 1'b0;
      w24_data  <= 1'b0;
    end else begin
      w24_valid <= frame_tick & word24;
      if (frame_tick && word24) w24_data <= f_bit[POL_POS];
    end
  end
endmodule

// File: rtl/stuff_twin_props.sv
module stuff_twin_props #(
  parameter int N_CH  = 16,
  parameter int SEL_W = $clog2(N_CH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_tick,
  input logic             word24,
  input logic [SEL_W-1:0] chan_sel,
  input logic [SEL_W-1:0] diag_sel,
  input logic [N_CH-1:0]  chan_on,
  input logic             self_test,
  input logic             pos_ack,
  input logic             neg_ack,
  input logic             pos_err,
  input logic             neg_err,
  input logic             stuff_err,
  input logic             w24_valid,
  input logic             w24_data
);
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_tick) |-> ($stable(pos_ack) && $stable(neg_ack))); // R3
  AST_NO_ERR_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frame_tick) && $past(chan_sel) == $past(diag_sel)) |-> !stuff_err); // R4
  AST_ERR_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_err || neg_err) |-> $past(frame_tick)); // R5
  AST_ERR_COMBINED: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_err |-> $past(frame_tick)); // R6
  AST_SELF_TEST_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frame_tick) && $past(self_test) && !$past(chan_on[chan_sel])) |-> pos_ack); // R8
  AST_W24_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    w24_valid |-> ($past(frame_tick) && $past(word24))); // R9
  AST_W24_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    w24_valid |-> (w24_data == pos_ack)); // R9
endmodule

bind stuff_twin_checker stuff_twin_props #(.N_CH(N_CH), .SEL_W(SEL_W)) u_props (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .word24(word24),
  .chan_sel(chan_sel), .diag_sel(diag_sel), .chan_on(chan_on),
  .self_test(self_test), .pos_ack(pos_ack), .neg_ack(neg_ack),
  .pos_err(pos_err), .neg_err(neg_err), .stuff_err(stuff_err),
  .w24_valid(w24_valid), .w24_data(w24_data)
);

// File: tb/test_stuff_twin_checker.sv
module test_stuff_twin_checker;
  localparam int NCH = 16;
  localparam int SW  = 4;
  localparam time CLK_PERIOD = 10ns;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           frame_tick = 1'b0;
  logic           word24 = 1'b0;
  logic [SW-1:0]  chan_sel = '0;
  logic [SW-1:0]  diag_sel = '0;
  logic [NCH-1:0] pos_req = '0;
  logic [NCH-1:0] neg_req = '0;
  logic [NCH-1:0] chan_on = '1;
  logic           self_test = 1'b0;
  logic pos_ack, neg_ack, pos_err, neg_err, stuff_err, w24_valid, w24_data;

  int checks = 0;
  int errors = 0;
  logic last_w24 = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stuff_twin_checker i_stuff_twin_checker (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .word24(word24),
    .chan_sel(chan_sel), .diag_sel(diag_sel), .pos_req(pos_req),
    .neg_req(neg_req), .chan_on(chan_on), .self_test(self_test),
    .pos_ack(pos_ack), .neg_ack(neg_ack), .pos_err(pos_err),
    .neg_err(neg_err), .stuff_err(stuff_err), .w24_valid(w24_valid),
    .w24_data(w24_data)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic logic cpos(input int ch);
    return chan_on[ch] ? pos_req[ch] : self_test;
  endfunction

  task automatic frame(input int s, input int d, input logic w24);
    logic ep, en, epe, ene;
    @(negedge clk);
    chan_sel = SW'(s); diag_sel = SW'(d); word24 = w24; frame_tick = 1'b1;
    ep  = cpos(s);
    en  = neg_req[s];
    epe = ep ^ cpos(d);
    ene = en ^ neg_req[d];
    @(negedge clk);
    frame_tick = 1'b0;
    chk(pos_ack, ep, "R2 R7 pos_ack");
    chk(neg_ack, en, "R2 neg_ack");
    chk(pos_err, epe, "R4 pos_err");
    chk(neg_err, ene, "R5 neg_err");
    chk(stuff_err, epe | ene, "R6 stuff_err");
    chk(w24_valid, w24, "R9 w24_valid");
    if (w24) last_w24 = ep;
    chk(w24_data, last_w24, "R9 w24_data");
    pos_req = ~pos_req; neg_req = ~neg_req;
    @(negedge clk);
    chk(pos_ack, ep, "R3 pos_ack hold");
    chk(neg_ack, en, "R3 neg_ack hold");
    chk(stuff_err, 1'b0, "R4 R5 R6 error clears");
    chk(w24_valid, 1'b0, "R9 strobe clears");
    pos_req = ~pos_req; neg_req = ~neg_req;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(pos_ack | neg_ack | stuff_err | w24_valid | w24_data, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(pos_ack | neg_ack | pos_err | neg_err | stuff_err | w24_valid | w24_data,
        1'b0, "R1 after reset");

    for (int mode = 0; mode < 3; mode++) begin
      chan_on   = (mode == 0) ? 16'hFFFF : 16'hA5C3;
      self_test = (mode == 2);
      for (int pat = 0; pat < 4; pat++) begin
        for (int s = 0; s < NCH; s++) begin
          logic [NCH-1:0] p, n;
          case (pat)
            0: begin p = NCH'(1) << s;    n = ~(NCH'(1) << s); end
            1: begin p = ~(NCH'(1) << s); n = NCH'(1) << s;    end
            2: begin p = 16'h5555;        n = 16'h3333;        end
            default: begin p = NCH'((s * 16'h9E37) ^ 16'h1D2B); n = NCH'((s * 16'h4F1B) + 16'h0777); end
          endcase
          pos_req = p; neg_req = n;
          frame(s, s, ((s + pat) % 3) == 0);
          frame(s, (s + pat + 1) % NCH, (s % 4) == 1);
        end
      end
    end

    // R8: out-of-service channels under self-test read 1 in both copies
    chan_on = 16'h00FF; self_test = 1'b1; pos_req = 16'h0000; neg_req = 16'h0000;
    frame(9, 12, 1'b1);
    chk(pos_ack, 1'b1, "R8 self-test level");
    self_test = 1'b0; pos_req = 16'hFF00;
    frame(10, 11, 1'b0);
    chk(pos_ack, 1'b0, "R7 off channel follows low level");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule